// File: doc/BRIEF.md
# Vector Mismatch-Shaping Element Selector

This block decides which unit elements of a multi-level unit-element DAC are switched on each clock. It holds one small digital noise-shaping loop per element. All loops share a single quantizer that picks the requested number of elements. Because each element's usage is fed back through its own loop, the error caused by element mismatch is pushed to high frequencies. The converter's oversampling then moves that error out of band, and no knowledge of the actual mismatch values is needed.

Each cycle, every loop forms a filtered value from its stored error history and negates it. The smallest of these values is subtracted from all of them, so the quantizer inputs are nonnegative and the smallest one is zero. The requested number of loops with the largest inputs are set to one. Each loop then stores its new error, which is its selected bit minus its quantizer input. A parameter picks first-order shaping (filter z^-1) or second-order shaping (filter 2z^-1 - z^-2). All arithmetic is signed integer, and the bits are registered before they leave the block.

Top module: `vec_mm_selector`

## Requirements
- R1: While `rst_n` is low, `enable_o` is all zeros and every stored error is zero. After reset, the first selection with all-equal inputs picks the lowest-indexed elements, so level 3 gives `enable_o` = 8'h07 for NUM_EL = 8.
- R2: The value on `level_i` at a rising edge sets `enable_o` at that same edge, and exactly that many bits of `enable_o` are one.
- R3: A `level_i` value above NUM_EL is treated as NUM_EL.
- R4: The ones go to the loops with the largest quantizer inputs. Among equal inputs, the lower element index wins.
- R5: With SHAPE_FIRST, loop i's quantizer input is -e_i(n-1) minus the shared offset. After reset, level 3 followed by level 3 gives 8'h07 and then 8'h38.
- R6: With SHAPE_SECOND, loop i's quantizer input is e_i(n-2) - 2*e_i(n-1) minus the shared offset.
- R7: Level 0 gives all zeros and level NUM_EL gives all ones. The error histories still update in both cases, and this shows in later selections.
- R8: The stored error e_i(n) = x_i(n) - w_i(n) always fits in ERR_W signed bits.
- R9: The shared offset is the minimum of the unoffset values, so in every cycle at least one quantizer input is exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_i | input | $clog2(NUM_EL+1) | Requested number of active elements |
| enable_o | output | NUM_EL | Registered element enables; bit i drives element i |

## Verification
The bench builds two copies of the block with NUM_EL = 8 and ERR_W = 16. One copy uses second-order shaping and the other first-order shaping, and both are driven with the same level sequence. Building both orders exercises both variants of the loop-filter generate branch. It also shows that they diverge from the same stimulus, because a cycle-accurate integer model of each recursion is compared against its own copy. With eight elements, the full range from empty to full can be reached, as can the out-of-range level codes 9 to 15 and all-equal ties right after reset.

// File: rtl/msel_pkg.sv
package msel_pkg;

    typedef enum logic {
        SHAPE_FIRST  = 1'b0,
        SHAPE_SECOND = 1'b1
    } shape_e;

endpackage

// File: rtl/msel_loop_filter.sv
module msel_loop_filter
    import msel_pkg::*;
#(
    parameter int     ERR_W = 16,
    parameter int     SUM_W = ERR_W + 2,
    parameter shape_e ORDER = SHAPE_SECOND
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_i,
    input  logic signed [SUM_W-1:0] quant_in_i,
    output logic signed [SUM_W-1:0] shaped_o
);

    logic signed [ERR_W-1:0] err_d1_q;
    logic signed [SUM_W-1:0] err_full;
    logic signed [ERR_W-1:0] err_next;
    logic signed [SUM_W-1:0] d1_ext;

    assign d1_ext   = {{2{err_d1_q[ERR_W-1]}}, err_d1_q};
    assign err_full = $signed({{(SUM_W-1){1'b0}}, bit_i}) - quant_in_i;
    assign err_next = err_full[ERR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_d1_q <= '0;
        end else begin
            err_d1_q <= err_next;
        end
    end

    generate
        if (ORDER == SHAPE_SECOND) begin : g_second
            logic signed [ERR_W-1:0] err_d2_q;
            logic signed [SUM_W-1:0] d2_ext;

            assign d2_ext = {{2{err_d2_q[ERR_W-1]}}, err_d2_q};

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    err_d2_q <= '0;
                end else begin
                    err_d2_q <= err_d1_q;
                end
            end

            // Negated filter output: -(2 e(n-1) - e(n-2))
            assign shaped_o = d2_ext - (d1_ext <<< 1);
        end else begin : g_first
            // Negated filter output: -e(n-1)
            assign shaped_o = -d1_ext;
        end
    endgenerate

    // R8: the error computed at full width survives truncation to ERR_W
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_full == {{2{err_next[ERR_W-1]}}, err_next});

endmodule

// File: rtl/msel_min_offset.sv
module msel_min_offset #(
    parameter int NUM_EL = 8,
    parameter int SUM_W  = 18
) (
    input  logic signed [SUM_W-1:0] shaped_i [NUM_EL],
    output logic signed [SUM_W-1:0] quant_o  [NUM_EL]
);

    logic signed [SUM_W-1:0] floor_val;

    always_comb begin
        floor_val = shaped_i[0];
        for (int idx = 1; idx < NUM_EL; idx++) begin
            if (shaped_i[idx] < floor_val) begin
                floor_val = shaped_i[idx];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_EL; g++) begin : g_sub
            assign quant_o[g] = shaped_i[g] - floor_val;
        end
    endgenerate

endmodule

// File: rtl/msel_topk_select.sv
module msel_topk_select #(
    parameter int NUM_EL = 8,
    parameter int SUM_W  = 18,
    parameter int LVL_W  = $clog2(NUM_EL + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [SUM_W-1:0] quant_i [NUM_EL],
    input  logic [LVL_W-1:0]        count_i,
    output logic [NUM_EL-1:0]       pick_o
);

    generate
        for (genvar gi = 0; gi < NUM_EL; gi++) begin : g_rank
            logic [LVL_W-1:0] ahead;

            always_comb begin
                ahead = '0;
                for (int j = 0; j < NUM_EL; j++) begin
                    if (j != gi) begin
                        if ((quant_i[j] > quant_i[gi]) ||
                            ((quant_i[j] == quant_i[gi]) && (j < gi))) begin
                            ahead = ahead + LVL_W'(1);
                        end
                    end
                end
            end

            assign pick_o[gi] = (ahead < count_i);
        end
    endgenerate

    // R4: a picked loop never has a smaller input than an unpicked one
    generate
        for (genvar a = 0; a < NUM_EL; a++) begin : g_chk_a
            for (genvar b = 0; b < NUM_EL; b++) begin : g_chk_b
                if (a != b) begin : g_pair
                    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
                        (pick_o[a] && !pick_o[b]) |-> (quant_i[a] >= quant_i[b]));
                end
            end
        end
    endgenerate

endmodule

// File: rtl/vec_mm_selector.sv
module vec_mm_selector
    import msel_pkg::*;
#(
    parameter int     NUM_EL = 8,
    parameter int     ERR_W  = 16,
    parameter shape_e ORDER  = SHAPE_SECOND,
    parameter int     LVL_W  = $clog2(NUM_EL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  level_i,
    output logic [NUM_EL-1:0] enable_o
);

    localparam int SUM_W = ERR_W + 2;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(NUM_EL);

    logic [LVL_W-1:0]        level_sat;
    logic signed [SUM_W-1:0] shaped [NUM_EL];
    logic signed [SUM_W-1:0] quant  [NUM_EL];
    logic [NUM_EL-1:0]       pick;
    logic [NUM_EL-1:0]       zero_hit;
    logic                    live_q;

    assign level_sat = (level_i > FULL_LVL) ? FULL_LVL : level_i;

    generate
        for (genvar g = 0; g < NUM_EL; g++) begin : g_loop
            msel_loop_filter #(
                .ERR_W (ERR_W),
                .SUM_W (SUM_W),
                .ORDER (ORDER)
            ) i_loop (
                .clk        (clk),
                .rst_n      (rst_n),
                .bit_i      (pick[g]),
                .quant_in_i (quant[g]),
                .shaped_o   (shaped[g])
            );
            assign zero_hit[g] = (quant[g] == '0);
        end
    endgenerate

    msel_min_offset #(
        .NUM_EL (NUM_EL),
        .SUM_W  (SUM_W)
    ) i_offset (
        .shaped_i (shaped),
        .quant_o  (quant)
    );

    msel_topk_select #(
        .NUM_EL (NUM_EL),
        .SUM_W  (SUM_W),
        .LVL_W  (LVL_W)
    ) i_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .quant_i (quant),
        .count_i (level_sat),
        .pick_o  (pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_o <= '0;
            live_q   <= 1'b0;
        end else begin
            enable_o <= pick;
            live_q   <= 1'b1;
        end
    end

    // R1: reset forces the outputs to zero
    p_rst_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (enable_o == '0));

    // R2 and R3: population of the output equals the clamped level of the prior edge
    p_popcount_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ($countones(enable_o) ==
                    (($past(level_i) > FULL_LVL) ? NUM_EL : int'($past(level_i)))));

    // R7: the extreme levels give empty and full vectors
    p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(level_i) == '0) |-> (enable_o == '0));
    p_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(level_i) >= FULL_LVL) |-> (&enable_o));

    // R9: after the offset, at least one quantizer input is zero
    p_min_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        |zero_hit);

endmodule

// File: tb/test_vec_mm_selector.sv
module test_vec_mm_selector;
    import msel_pkg::*;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] level = '0;
    logic [N-1:0] en2;
    logic [N-1:0] en1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state: index 0 = first order, 1 = second order
    int me1 [2][N];
    int me2 [2][N];
    logic [N-1:0] mx [2];

    always #2 clk = ~clk;

    vec_mm_selector #(.NUM_EL(N), .ERR_W(16), .ORDER(SHAPE_SECOND)) i_vec_mm_selector (
        .clk(clk), .rst_n(rst_n), .level_i(level), .enable_o(en2));

    vec_mm_selector #(.NUM_EL(N), .ERR_W(16), .ORDER(SHAPE_FIRST)) i_vec_mm_selector_o1 (
        .clk(clk), .rst_n(rst_n), .level_i(level), .enable_o(en1));

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int o = 0; o < 2; o++) begin
            mx[o] = '0;
            for (int i = 0; i < N; i++) begin
                me1[o][i] = 0;
                me2[o][i] = 0;
            end
        end
    endtask

    task automatic model_step(input int lvl);
        int s [N];
        int w [N];
        int mn;
        int kk;
        int ahead;
        kk = (lvl > N) ? N : lvl;
        for (int o = 0; o < 2; o++) begin
            for (int i = 0; i < N; i++) begin
                s[i] = (o == 1) ? (me2[o][i] - 2 * me1[o][i]) : -me1[o][i];
            end
            mn = s[0];
            for (int i = 1; i < N; i++) if (s[i] < mn) mn = s[i];
            for (int i = 0; i < N; i++) w[i] = s[i] - mn;   // R9 offset
            for (int i = 0; i < N; i++) begin
                ahead = 0;
                for (int j = 0; j < N; j++) begin
                    if (j != i && (w[j] > w[i] || (w[j] == w[i] && j < i))) ahead++;
                end
                mx[o][i] = (ahead < kk);
            end
            for (int i = 0; i < N; i++) begin
                me2[o][i] = me1[o][i];
                me1[o][i] = int'(mx[o][i]) - w[i];
            end
        end
    endtask

    function automatic int pop(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    // drive one level, called at a negedge, returns at the next negedge
    task automatic drive(input int lvl, input string req);
        level = 4'(lvl);
        @(posedge clk);
        model_step(lvl);
        @(negedge clk);
        chk({req, " second-order model"}, en2, mx[1]);
        chk({req, " first-order model"}, en1, mx[0]);
        chk_int({req, " R2 popcount"}, pop(en2), (lvl > N) ? N : lvl);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset output second", en2, '0);
        chk("R1 reset output first", en1, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_and_rotate();
        do_reset();
        drive(3, "R1");
        chk("R1 tie to low index", en2, 8'h07);
        drive(3, "R5");
        chk("R5 first-order second step", en1, 8'h38);
        chk("R6 second-order second step", en2, 8'h38);
    endtask

    task automatic t_ties();
        do_reset();
        drive(1, "R4");
        chk("R4 single pick lowest index", en1, 8'h01);
        drive(1, "R4");
        chk("R4 next pick after used", en1, 8'h02);
    endtask

    task automatic t_constant();
        do_reset();
        for (int c = 0; c < 40; c++) drive(5, "R6 constant level");
    endtask

    task automatic t_extremes();
        do_reset();
        drive(0, "R7");
        chk("R7 level zero empty", en2, 8'h00);
        drive(8, "R7");
        chk("R7 full level", en2, 8'hFF);
        drive(3, "R7");
        drive(1, "R7 history after extremes");
        drive(2, "R7 history after extremes");
    endtask

    task automatic t_saturate();
        do_reset();
        drive(2, "R3");
        drive(12, "R3");
        chk("R3 clamp second", en2, 8'hFF);
        chk("R3 clamp first", en1, 8'hFF);
        drive(15, "R3");
        drive(4, "R3 after clamp");
    endtask

    task automatic t_sweep();
        logic [7:0] lfsr = 8'hA5;
        do_reset();
        for (int c = 0; c < 300; c++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            drive(int'(lfsr) % 9, "R4 R8 sweep");
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset_and_rotate();
        t_ties();
        t_constant();
        t_extremes();
        t_saturate();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog req=all actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule